// File: doc/BRIEF.md
# Delay-Slot Next-PC Unit

This block sequences the program counter of a 32-bit core that executes one instruction after every control transfer, the delay slot. It holds three addresses: the current fetch address, the address that follows it, and the address after that. Each cycle it receives a decoded description of the instruction at the current address: whether that instruction transfers control, of which kind, the result of its condition, whether it links, whether it is a "likely" branch, its 16-bit offset, its 26-bit jump field and a register operand. From these it advances the three addresses, raises a write request for the link register (register 31), and flags a delay-slot instruction that must be discarded.

A taken transfer never disturbs the instruction right behind it. That delay-slot instruction still runs, and the target is fetched after it. A likely branch that is not taken turns its delay-slot instruction into a no-op. The unit marks that instruction with a one-cycle annul flag so that later stages drop its writes. While the flag is high, the unit itself ignores the descriptor it receives.

Top module: `dslot_pc_seq`

## Requirements
- R1: While rst_n is low at a clock edge, pc loads RESET_VEC, npc loads RESET_VEC+4, nnpc loads RESET_VEC+8, and annul is low.
- R2: With xfer_valid low, each clock edge moves pc to npc and npc to nnpc, and sets nnpc to the old nnpc plus 4.
- R3: A taken branch (kind 0 with cond_true high, or kind 1) uses a displacement equal to imm16 shifted left by two, sign-extended from bit 17. At the next edge pc takes npc, npc takes npc plus the displacement, and nnpc takes that target plus 4.
- R4: A conditional branch (kind 0) with cond_true low and likely_en low advances exactly as in R2, and annul stays low.
- R5: A likely conditional branch (kind 0, likely_en high) with cond_true low moves pc to the old npc, npc to the old nnpc and nnpc to the old nnpc plus 4, and raises annul for exactly the following cycle. A taken likely branch does not raise annul.
- R6: A valid descriptor with link_en high drives link_we high in the same cycle, with link_data equal to the current nnpc.
- R7: A direct jump (kind 2) targets bits 31..28 of pc+4 joined with jtarg26 shifted left by two. At the next edge pc takes npc, npc takes the target, and nnpc takes the target plus 4.
- R8: A register jump (kind 3) targets reg_val with bits 1..0 cleared, ORed with bit 0 of pc+4. The registers then advance as in R7.
- R9: Kinds 1, 2 and 3 are taken whatever the value of cond_true. likely_en has no effect on kinds 1, 2 and 3.
- R10: In a cycle where annul is high, the descriptor is ignored. link_we stays low, the registers advance as in R2, and annul falls at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_valid | input | 1 | Instruction at pc is a control transfer |
| xfer_kind | input | 2 | 0 conditional branch, 1 unconditional branch, 2 direct jump, 3 register jump |
| cond_true | input | 1 | Branch condition result |
| link_en | input | 1 | Instruction writes the return address |
| likely_en | input | 1 | Branch annuls its delay slot when not taken |
| imm16 | input | 16 | Branch offset field in words |
| jtarg26 | input | 26 | Direct jump field in words |
| reg_val | input | 32 | Register operand of a register jump |
| pc | output | 32 | Current instruction address |
| npc | output | 32 | Next instruction address |
| nnpc | output | 32 | Address after next |
| link_we | output | 1 | Write request for register 31 |
| link_data | output | 32 | Return address to write |
| annul | output | 1 | Instruction at pc is an annulled delay slot |

## Verification
link_we and link_data are combinational. They are due in the same cycle as the descriptor, so the bench drives inputs on the falling edge and samples those two outputs a moment later. The address triple and annul are registered. Their results are due one rising edge after the descriptor, and the bench compares them on the following falling edge against a model that it advances by one step per edge. Annul is also checked on the cycle after it rises, so the bench confirms that it lasts exactly one cycle and that the descriptor presented during it has no effect.

// File: rtl/dspc_pkg.sv
// Package: shared encodings for the delay-slot next-PC unit.
// Assumes: the transfer kind is a 2-bit code produced by the decoder.
package dspc_pkg;

    typedef enum logic [1:0] {
        XK_BCOND = 2'd0,   // conditional PC-relative branch
        XK_BUNC  = 2'd1,   // unconditional PC-relative branch
        XK_JDIR  = 2'd2,   // direct region jump
        XK_JREG  = 2'd3    // register-indirect jump
    } xfer_kind_e;

endpackage

// File: rtl/dspc_target.sv
// Module: dspc_target
// Computes the redirect address for each transfer kind.
// Assumes: AW >= IMM_W + 3 and the jump field is AW-6 bits wide.
module dspc_target
    import dspc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IMM_W = 16,
    parameter int JF_W  = AW - 6
) (
    input  xfer_kind_e        kind,
    input  logic [AW-1:0]     pc,
    input  logic [AW-1:0]     npc,
    input  logic [IMM_W-1:0]  imm,
    input  logic [JF_W-1:0]   jfield,
    input  logic [AW-1:0]     regv,
    output logic [AW-1:0]     target
);
    localparam int DISP_W = IMM_W + 2;
    localparam int SEXT_W = AW - DISP_W;

    logic [DISP_W-1:0] disp_raw;
    logic [AW-1:0]     disp;
    logic [AW-1:0]     pc_plus4;
    logic [AW-1:0]     br_tgt;
    logic [AW-1:0]     jd_tgt;
    logic [AW-1:0]     jr_tgt;

    // Word offset to a byte displacement, sign-extended from its top bit.
    always_comb begin
        disp_raw = {imm, 2'b00};
        disp     = {{SEXT_W{disp_raw[DISP_W-1]}}, disp_raw};
    end

    // Candidate targets for each kind.
    always_comb begin
        pc_plus4 = pc + AW'(4);
        br_tgt   = npc + disp;
        jd_tgt   = {pc_plus4[AW-1:AW-4], jfield, 2'b00};
        jr_tgt   = {regv[AW-1:2], 2'b00} | {{(AW-1){1'b0}}, pc_plus4[0]};
    end

    // Select the target for the kind presented.
    always_comb begin
        unique case (kind)
            XK_BCOND, XK_BUNC: target = br_tgt;
            XK_JDIR:           target = jd_tgt;
            default:           target = jr_tgt;
        endcase
    end

endmodule

// File: rtl/dspc_decide.sv
// Module: dspc_decide
// Decides redirect, delay-slot squash and link write for one descriptor.
// Assumes: the descriptor describes the instruction at the current pc;
// a descriptor that arrives while annul is high belongs to a squashed slot.
module dspc_decide
    import dspc_pkg::*;
(
    input  logic        rst_n,
    input  logic        valid,
    input  xfer_kind_e  kind,
    input  logic        cond,
    input  logic        link,
    input  logic        likely,
    input  logic        annul_q,
    output logic        redirect,
    output logic        squash,
    output logic        link_we
);
    logic live;
    logic is_cond;

    // A descriptor counts only out of reset and outside an annulled slot.
    always_comb begin
        live    = rst_n && valid && !annul_q;
        is_cond = (kind == XK_BCOND);
    end

    // Jumps and unconditional branches always redirect; conditional ones on cond.
    always_comb begin
        redirect = live && (!is_cond || cond);
        squash   = live && is_cond && likely && !cond;
        link_we  = live && link;
    end

endmodule

// File: rtl/dspc_pcregs.sv
// Module: dspc_pcregs
// Holds the pc/npc/nnpc triple and the registered annul flag.
// Assumes: synchronous active-low reset; redirect and squash are exclusive.
module dspc_pcregs #(
    parameter int          AW        = 32,
    parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redirect,
    input  logic          squash,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] npc_q,
    output logic [AW-1:0] nnpc_q,
    output logic          annul_q
);
    localparam logic [AW-1:0] STEP = AW'(4);
    localparam logic [AW-1:0] RV   = AW'(RESET_VEC);

    logic [AW-1:0] follow;

    // Address that comes after the delay slot.
    always_comb begin
        follow = redirect ? target : nnpc_q;
    end

    // Advance the triple one instruction per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= RV;
            npc_q  <= RV + STEP;
            nnpc_q <= RV + STEP + STEP;
        end else begin
            pc_q   <= npc_q;
            npc_q  <= follow;
            nnpc_q <= follow + STEP;
        end
    end

    // Flag the delay-slot instruction of a not-taken likely branch.
    always_ff @(posedge clk) begin
        if (!rst_n) annul_q <= 1'b0;
        else        annul_q <= squash;
    end

endmodule

// File: rtl/dslot_pc_seq.sv
// Module: dslot_pc_seq (top)
// Next-PC sequencer with one delay slot and likely-branch annulment.
// Assumes: decode, condition evaluation and register read happen upstream;
// exceptions do not redirect through this block.
module dslot_pc_seq
    import dspc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'hBFC0_0000,
    parameter int          AW        = 32,
    parameter int          IMM_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_valid,
    input  logic [1:0]        xfer_kind,
    input  logic              cond_true,
    input  logic              link_en,
    input  logic              likely_en,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [AW-7:0]     jtarg26,
    input  logic [AW-1:0]     reg_val,
    output logic [AW-1:0]     pc,
    output logic [AW-1:0]     npc,
    output logic [AW-1:0]     nnpc,
    output logic              link_we,
    output logic [AW-1:0]     link_data,
    output logic              annul
);
    localparam int JF_W = AW - 6;

    xfer_kind_e    kind;
    logic          redirect;
    logic          squash;
    logic [AW-1:0] target;

    // Map the raw kind code onto the shared enum.
    always_comb begin
        kind = xfer_kind_e'(xfer_kind);
    end

    dspc_decide u_decide (
        .rst_n    (rst_n),
        .valid    (xfer_valid),
        .kind     (kind),
        .cond     (cond_true),
        .link     (link_en),
        .likely   (likely_en),
        .annul_q  (annul),
        .redirect (redirect),
        .squash   (squash),
        .link_we  (link_we)
    );

    dspc_target #(.AW(AW), .IMM_W(IMM_W), .JF_W(JF_W)) u_target (
        .kind   (kind),
        .pc     (pc),
        .npc    (npc),
        .imm    (imm16),
        .jfield (jtarg26),
        .regv   (reg_val),
        .target (target)
    );

    dspc_pcregs #(.AW(AW), .RESET_VEC(RESET_VEC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .redirect (redirect),
        .squash   (squash),
        .target   (target),
        .pc_q     (pc),
        .npc_q    (npc),
        .nnpc_q   (nnpc),
        .annul_q  (annul)
    );

    // Return address is the instruction after the delay slot.
    always_comb begin
        link_data = nnpc;
    end

endmodule

// File: rtl/dspc_checker.sv
// Module: dspc_checker
// Temporal checks on the next-PC unit, attached by bind.
// Assumes: the ports of dslot_pc_seq with their default widths.
module dspc_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_valid,
    input logic [1:0]    xfer_kind,
    input logic          cond_true,
    input logic          likely_en,
    input logic          link_we,
    input logic          annul,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] npc,
    input logic [AW-1:0] nnpc
);
    logic likely_miss;

    // Descriptor of a not-taken likely branch outside an annulled slot.
    always_comb begin
        likely_miss = xfer_valid && !annul && xfer_kind == 2'd0 && likely_en && !cond_true;
    end

    // The two fetch-ahead addresses stay one word apart.
    assert_nnpc_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> nnpc == npc + AW'(4));

    // Without a transfer, pc steps to the old npc.
    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_valid && !annul) |=> pc == $past(npc));

    // A not-taken likely branch raises annul next.
    assert_likely_annul_R5: assert property (@(posedge clk) disable iff (!rst_n)
        likely_miss |=> (annul && pc == $past(npc) && npc == $past(nnpc)));

    // Annul lasts a single cycle.
    assert_annul_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        annul |=> !annul);

    // No link write from an annulled slot.
    assert_annul_nolink_R10: assert property (@(posedge clk) disable iff (!rst_n)
        annul |-> !link_we);

    // A jump never raises annul.
    assert_jump_noannul_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_kind[1]) |=> !annul);

endmodule

bind dslot_pc_seq dspc_checker #(.AW(AW)) u_dspc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_valid (xfer_valid),
    .xfer_kind  (xfer_kind),
    .cond_true  (cond_true),
    .likely_en  (likely_en),
    .link_we    (link_we),
    .annul      (annul),
    .pc         (pc),
    .npc        (npc),
    .nnpc       (nnpc)
);

// File: tb/test_dslot_pc_seq.sv
// Bench for dslot_pc_seq: directed corners plus seeded random descriptors
// checked against a step model kept in bench functions.
module test_dslot_pc_seq;

    localparam logic [31:0] RV = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_valid = 1'b0;
    logic [1:0]  xfer_kind = 2'd0;
    logic        cond_true = 1'b0;
    logic        link_en = 1'b0;
    logic        likely_en = 1'b0;
    logic [15:0] imm16 = '0;
    logic [25:0] jtarg26 = '0;
    logic [31:0] reg_val = '0;
    logic [31:0] pc, npc, nnpc, link_data;
    logic        link_we, annul;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_pc, m_npc, m_nnpc;
    logic        m_annul;

    always #10 clk = ~clk;

    dslot_pc_seq #(.RESET_VEC(RV)) i_dslot_pc_seq (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_kind(xfer_kind),
        .cond_true(cond_true), .link_en(link_en), .likely_en(likely_en),
        .imm16(imm16), .jtarg26(jtarg26), .reg_val(reg_val),
        .pc(pc), .npc(npc), .nnpc(nnpc), .link_we(link_we),
        .link_data(link_data), .annul(annul)
    );

    function automatic logic [31:0] f_disp(input logic [15:0] im);
        logic [17:0] raw;
        raw = {im, 2'b00};
        return {{14{raw[17]}}, raw};
    endfunction

    function automatic logic [31:0] f_target(input logic [1:0] k, input logic [31:0] p,
                                             input logic [31:0] np, input logic [15:0] im,
                                             input logic [25:0] jt, input logic [31:0] rv);
        logic [31:0] p4;
        p4 = p + 32'd4;
        case (k)
            2'd0, 2'd1: return np + f_disp(im);
            2'd2:       return {p4[31:28], jt, 2'b00};
            default:    return (rv & ~32'd3) | {31'd0, p4[0]};
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one descriptor at the falling edge, check link now and the
    // registered outputs one rising edge later.
    task automatic step(input string tag, input logic v, input logic [1:0] k, input logic c,
                        input logic ln, input logic lk, input logic [15:0] im,
                        input logic [25:0] jt, input logic [31:0] rv);
        logic live, taken, miss;
        logic [31:0] fol;
        xfer_valid = v; xfer_kind = k; cond_true = c; link_en = ln;
        likely_en = lk; imm16 = im; jtarg26 = jt; reg_val = rv;
        #1;
        live  = v && !m_annul;
        taken = live && (k != 2'd0 || c);
        miss  = live && k == 2'd0 && lk && !c;
        check({tag, " R6 link_we"}, {31'd0, link_we}, {31'd0, live && ln});
        if (live && ln) check({tag, " R6 link_data"}, link_data, m_nnpc);
        fol = taken ? f_target(k, m_pc, m_npc, im, jt, rv) : m_nnpc;
        m_pc = m_npc; m_npc = fol; m_nnpc = fol + 32'd4; m_annul = miss;
        @(posedge clk);
        @(negedge clk);
        check({tag, " pc"}, pc, m_pc);
        check({tag, " npc"}, npc, m_npc);
        check({tag, " nnpc"}, nnpc, m_nnpc);
        check({tag, " annul"}, {31'd0, annul}, {31'd0, m_annul});
    endtask

    initial begin
        #3_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 pc", pc, RV);
        check("R1 npc", npc, RV + 32'd4);
        check("R1 nnpc", nnpc, RV + 32'd8);
        check("R1 annul", {31'd0, annul}, 32'd0);
        rst_n = 1'b1;
        m_pc = RV; m_npc = RV + 32'd4; m_nnpc = RV + 32'd8; m_annul = 1'b0;

        step("R2 idle", 0, 2'd0, 1, 1, 0, 16'h0010, '0, '0);
        step("R3 fwd taken", 1, 2'd0, 1, 0, 0, 16'h0020, '0, '0);
        step("R3 slot", 0, 2'd0, 0, 0, 0, '0, '0, '0);
        step("R3 neg sext", 1, 2'd0, 1, 0, 0, 16'h8000, '0, '0);
        step("R2 after", 0, 2'd0, 0, 0, 0, '0, '0, '0);
        step("R4 not taken", 1, 2'd0, 0, 1, 0, 16'h7fff, '0, '0);
        step("R5 likely miss", 1, 2'd0, 0, 1, 1, 16'h0040, '0, '0);
        step("R10 ignored", 1, 2'd2, 1, 1, 0, '0, 26'h3ff_ffff, '0);
        step("R5 likely hit", 1, 2'd0, 1, 0, 1, 16'hfff0, '0, '0);
        step("R9 uncond", 1, 2'd1, 0, 1, 1, 16'h0004, '0, '0);
        step("R7 jdir", 1, 2'd2, 0, 1, 1, '0, 26'h123_4567, '0);
        step("R8 jreg", 1, 2'd3, 0, 1, 0, '0, '0, 32'h8000_1237);
        step("R2 idle2", 0, 2'd0, 0, 0, 0, '0, '0, '0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            step("R2-R10 random", r[0] | r[1], r[3:2], r[4], r[5], r[6] & r[7],
                 16'($urandom), 26'($urandom), $urandom);
        end

        // R1 again mid-run
        rst_n = 1'b0;
        xfer_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 re-reset pc", pc, RV);
        check("R1 re-reset annul", {31'd0, annul}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule